// File: doc/BRIEF.md
# Tri-State GPIO Port Register Bank

This block gives a small 8-bit processor core three general-purpose I/O ports that it reaches through its register-file bus. Port A is four bits wide. Ports B and C are eight bits wide. Each port has an output latch and a per-pin direction register. The pad controls it produces are an output value and an active-high output enable for every pin. Live pad levels pass through a synchronizer and are returned on reads.

An ordinary register write to a port address updates only that port's output latch. The direction of a port is set by a separate load strobe. That strobe copies the accumulator value, carried on the same write-data bus, into the direction register of the port named by the address. A direction register cannot be read back.

The block takes two resets. Power-on reset leaves the output latches undefined. The other reset leaves the latches untouched. Either reset turns every pin into an input. A build parameter turns port C into a plain read/write register that has no pad connection.

Top module: `gpio_port_bank`

## Requirements
- R1: While either reset is asserted, and after it is released until the next direction load, every pad output enable of every port is 0. Every pin is then an input.
- R2: When `dir_ld` is high and `reg_addr` is 05h (A), 06h (B) or 07h (C), `reg_wdata` is copied into that port's direction register at the clock edge. Each pin's enable then equals the inverse of its own direction bit, so 0 means drive and 1 means high impedance. A direction load to any other address, and the direction registers of the other ports, stay unchanged.
- R3: A write (`reg_wr_en` high) to a port address loads that port's output latch at the clock edge. The latch is loaded whether or not the pins drive, and the pad output value follows it. The latches of the other ports are unchanged.
- R4: A read of a port address returns the pad input levels as they were two clock edges earlier. The direction setting and the latch content do not affect the result. A pin that is driven high but held low outside reads as 0.
- R5: Port A uses only bits [3:0] of writes and direction loads. A read of 05h always returns 0 in bits [7:4].
- R6: The output latches keep their content through the non-power-on reset (`rst_n`). They change only on a write.
- R7: With `PORT_C_IO` = 0, port C is a read/write register. A read of 07h returns the last value written, whatever the pads do. The port C pad output value and enable stay 0, and direction loads to 07h have no effect.
- R8: A read of any address other than 05h, 06h and 07h returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | External or watchdog reset, active low, asynchronous |
| reg_addr | input | ADDR_W | Register-file address for reads, writes and direction loads |
| reg_wr_en | input | 1 | Writes `reg_wdata` into the addressed port latch |
| dir_ld | input | 1 | Loads `reg_wdata` into the addressed port's direction register |
| reg_wdata | input | DATA_W | Write data or accumulator value |
| rd_data | output | DATA_W | Read value for `reg_addr` |
| pad_in_a | input | A_WIDTH | Port A pad input levels |
| pad_out_a | output | A_WIDTH | Port A pad output values |
| pad_oe_a | output | A_WIDTH | Port A pad output enables, active high |
| pad_in_b | input | B_WIDTH | Port B pad input levels |
| pad_out_b | output | B_WIDTH | Port B pad output values |
| pad_oe_b | output | B_WIDTH | Port B pad output enables, active high |
| pad_in_c | input | C_WIDTH | Port C pad input levels |
| pad_out_c | output | C_WIDTH | Port C pad output values |
| pad_oe_c | output | C_WIDTH | Port C pad output enables, active high |

## Verification
The bench drives a pin low while the latch drives it high. A design that returned the latch on reads would show a 1 on that bit. The bench samples a changed pin after one edge and again after two. A design with the wrong synchronizer depth returns the new value too early or too late. The bench pulses the non-power-on reset with all three latches holding known values. A design that cleared the latches on that reset, or left the enables set after it, fails the readback of the latches and enables. The bench also checks direction loads to a non-port address, reads of the unimplemented port A bits and unmapped addresses, and a register-mode copy whose reads ignore the pads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   // Decoded per-port bus command
   typedef struct packed {
      logic wr;   // output-latch write
      logic ld;   // direction load
   } port_cmd_t;

   function automatic port_cmd_t decode_cmd(input logic hit, input logic wr_en,
                                            input logic ld_en);
      port_cmd_t c;
      c.wr = hit & wr_en;
      c.ld = hit & ld_en;
      return c;
   endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk) stage[0] <= d;

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) stage[s] <= stage[s-1];
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice
   import gpio_pkg::*;
#(
   parameter int WIDTH       = 8,
   parameter int DATA_W      = 8,
   parameter bit IS_IO       = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  port_cmd_t         cmd,
   input  logic [WIDTH-1:0]  din,
   input  logic [WIDTH-1:0]  pin_in,
   output logic [WIDTH-1:0]  pin_out,
   output logic [WIDTH-1:0]  pin_oe,
   output logic [DATA_W-1:0] rd_val
);
   logic [WIDTH-1:0] latch_q;

   // Output latch: no reset, so it is undefined after power-on and holds otherwise
   always_ff @(posedge clk) begin
      if (cmd.wr) latch_q <= din;
   end

   if (IS_IO) begin : g_io
      logic [WIDTH-1:0] dir_q;
      logic [WIDTH-1:0] pin_sync;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      dir_q <= '1;
         else if (cmd.ld) dir_q <= din;
      end

      gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
         .clk (clk),
         .d   (pin_in),
         .q   (pin_sync)
      );

      assign pin_out = latch_q;
      assign pin_oe  = ~dir_q;

      always_comb begin
         rd_val = '0;
         rd_val[WIDTH-1:0] = pin_sync;
      end
   end else begin : g_reg
      logic unused_inputs;
      assign unused_inputs = ^{pin_in, cmd.ld, rst_n};
      assign pin_out = '0;
      assign pin_oe  = '0;

      always_comb begin
         rd_val = '0;
         rd_val[WIDTH-1:0] = latch_q;
      end
   end
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
   import gpio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 5,
   parameter int A_WIDTH     = 4,
   parameter int B_WIDTH     = 8,
   parameter int C_WIDTH     = 8,
   parameter int ADDR_A      = 5,
   parameter int ADDR_B      = 6,
   parameter int ADDR_C      = 7,
   parameter bit PORT_C_IO   = 1'b1,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr_en,
   input  logic               dir_ld,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  rd_data,
   input  logic [A_WIDTH-1:0] pad_in_a,
   output logic [A_WIDTH-1:0] pad_out_a,
   output logic [A_WIDTH-1:0] pad_oe_a,
   input  logic [B_WIDTH-1:0] pad_in_b,
   output logic [B_WIDTH-1:0] pad_out_b,
   output logic [B_WIDTH-1:0] pad_oe_b,
   input  logic [C_WIDTH-1:0] pad_in_c,
   output logic [C_WIDTH-1:0] pad_out_c,
   output logic [C_WIDTH-1:0] pad_oe_c
);
   localparam logic [ADDR_W-1:0] LA = ADDR_A[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] LB = ADDR_B[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] LC = ADDR_C[ADDR_W-1:0];

   // Elaboration-time parameter checks
   if (A_WIDTH < 1 || A_WIDTH > DATA_W || B_WIDTH < 1 || B_WIDTH > DATA_W ||
       C_WIDTH < 1 || C_WIDTH > DATA_W) begin : g_bad_width
      $error("gpio_port_bank: port widths must lie in 1..DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("gpio_port_bank: SYNC_STAGES must be at least 2");
   end
   if (LA == LB || LA == LC || LB == LC) begin : g_bad_addr
      $error("gpio_port_bank: port addresses must be distinct");
   end
   if (ADDR_A >= (1 << ADDR_W) || ADDR_B >= (1 << ADDR_W) ||
       ADDR_C >= (1 << ADDR_W)) begin : g_bad_range
      $error("gpio_port_bank: port address exceeds ADDR_W");
   end

   // Either reset returns all directions to input
   logic rst_any_n;
   assign rst_any_n = por_n & rst_n;

   port_cmd_t cmd_a, cmd_b, cmd_c;
   assign cmd_a = decode_cmd(reg_addr == LA, reg_wr_en, dir_ld);
   assign cmd_b = decode_cmd(reg_addr == LB, reg_wr_en, dir_ld);
   assign cmd_c = decode_cmd(reg_addr == LC, reg_wr_en, dir_ld);

   logic [DATA_W-1:0] rd_a, rd_b, rd_c;

   gpio_port_slice #(.WIDTH(A_WIDTH), .DATA_W(DATA_W), .IS_IO(1'b1),
                     .SYNC_STAGES(SYNC_STAGES)) u_port_a (
      .clk(clk), .rst_n(rst_any_n), .cmd(cmd_a), .din(reg_wdata[A_WIDTH-1:0]),
      .pin_in(pad_in_a), .pin_out(pad_out_a), .pin_oe(pad_oe_a), .rd_val(rd_a)
   );

   gpio_port_slice #(.WIDTH(B_WIDTH), .DATA_W(DATA_W), .IS_IO(1'b1),
                     .SYNC_STAGES(SYNC_STAGES)) u_port_b (
      .clk(clk), .rst_n(rst_any_n), .cmd(cmd_b), .din(reg_wdata[B_WIDTH-1:0]),
      .pin_in(pad_in_b), .pin_out(pad_out_b), .pin_oe(pad_oe_b), .rd_val(rd_b)
   );

   gpio_port_slice #(.WIDTH(C_WIDTH), .DATA_W(DATA_W), .IS_IO(PORT_C_IO),
                     .SYNC_STAGES(SYNC_STAGES)) u_port_c (
      .clk(clk), .rst_n(rst_any_n), .cmd(cmd_c), .din(reg_wdata[C_WIDTH-1:0]),
      .pin_in(pad_in_c), .pin_out(pad_out_c), .pin_oe(pad_oe_c), .rd_val(rd_c)
   );

   // Read mux: unmapped addresses return zero
   always_comb begin
      unique case (reg_addr)
         LA:      rd_data = rd_a;
         LB:      rd_data = rd_b;
         LC:      rd_data = rd_c;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk #(
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 5,
   parameter int A_WIDTH   = 4,
   parameter int B_WIDTH   = 8,
   parameter int C_WIDTH   = 8,
   parameter int ADDR_A    = 5,
   parameter int ADDR_B    = 6,
   parameter int ADDR_C    = 7,
   parameter bit PORT_C_IO = 1'b1
) (
   input logic               clk,
   input logic               por_n,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               reg_wr_en,
   input logic               dir_ld,
   input logic [DATA_W-1:0]  rd_data,
   input logic [B_WIDTH-1:0] pad_in_b,
   input logic [A_WIDTH-1:0] pad_oe_a,
   input logic [B_WIDTH-1:0] pad_out_b,
   input logic [B_WIDTH-1:0] pad_oe_b,
   input logic [C_WIDTH-1:0] pad_out_c,
   input logic [C_WIDTH-1:0] pad_oe_c
);
   localparam logic [ADDR_W-1:0] LA = ADDR_A[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] LB = ADDR_B[ADDR_W-1:0];
   localparam logic [ADDR_W-1:0] LC = ADDR_C[ADDR_W-1:0];

   logic [1:0] since_por;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)               since_por <= '0;
      else if (since_por != 2'd3) since_por <= since_por + 2'd1;
   end

   AST_DIR_RESET: assert property (@(posedge clk)
      (!por_n || !rst_n) |=> (pad_oe_a == '0 && pad_oe_b == '0 && pad_oe_c == '0)); // R1

   AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      !dir_ld |=> ($stable(pad_oe_a) && $stable(pad_oe_b) && $stable(pad_oe_c))); // R2

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!por_n)
      (since_por != 2'd0 && !(reg_wr_en && reg_addr == LB)) |=> $stable(pad_out_b)); // R6

   AST_PIN_READBACK: assert property (@(posedge clk) disable iff (!por_n)
      (since_por >= 2'd2 && reg_addr == LB) |-> rd_data[B_WIDTH-1:0] == $past(pad_in_b, 2)); // R4

   AST_A_HIGH_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      (reg_addr == LA) |-> rd_data[DATA_W-1:A_WIDTH] == '0); // R5

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!por_n)
      (reg_addr != LA && reg_addr != LB && reg_addr != LC) |-> rd_data == '0); // R8

   if (!PORT_C_IO) begin : g_reg_chk
      AST_GPR_UNDRIVEN: assert property (@(posedge clk) disable iff (!por_n)
         dir_ld |=> (pad_oe_c == '0 && pad_out_c == '0)); // R7
   end
endmodule

bind gpio_port_bank gpio_port_bank_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .A_WIDTH(A_WIDTH), .B_WIDTH(B_WIDTH),
   .C_WIDTH(C_WIDTH), .ADDR_A(ADDR_A), .ADDR_B(ADDR_B), .ADDR_C(ADDR_C),
   .PORT_C_IO(PORT_C_IO)
) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_addr(reg_addr),
   .reg_wr_en(reg_wr_en), .dir_ld(dir_ld), .rd_data(rd_data),
   .pad_in_b(pad_in_b), .pad_oe_a(pad_oe_a), .pad_out_b(pad_out_b),
   .pad_oe_b(pad_oe_b), .pad_out_c(pad_out_c), .pad_oe_c(pad_oe_c)
);

// File: tb/gpio_port_bank_test.sv
`timescale 1ns/1ps
module gpio_port_bank_test;
   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       por_n, rst_n, reg_wr_en, dir_ld;
   logic [4:0] reg_addr;
   logic [7:0] reg_wdata, rd_data, g_rd_data;
   logic [3:0] pad_in_a, pad_out_a, pad_oe_a, g_out_a, g_oe_a;
   logic [7:0] pad_in_b, pad_out_b, pad_oe_b, g_out_b, g_oe_b;
   logic [7:0] pad_in_c, pad_out_c, pad_oe_c, g_out_c, g_oe_c;

   gpio_port_bank uut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_addr(reg_addr),
      .reg_wr_en(reg_wr_en), .dir_ld(dir_ld), .reg_wdata(reg_wdata), .rd_data(rd_data),
      .pad_in_a(pad_in_a), .pad_out_a(pad_out_a), .pad_oe_a(pad_oe_a),
      .pad_in_b(pad_in_b), .pad_out_b(pad_out_b), .pad_oe_b(pad_oe_b),
      .pad_in_c(pad_in_c), .pad_out_c(pad_out_c), .pad_oe_c(pad_oe_c)
   );

   gpio_port_bank #(.PORT_C_IO(1'b0)) uut_gpr (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .reg_addr(reg_addr),
      .reg_wr_en(reg_wr_en), .dir_ld(dir_ld), .reg_wdata(reg_wdata), .rd_data(g_rd_data),
      .pad_in_a(pad_in_a), .pad_out_a(g_out_a), .pad_oe_a(g_oe_a),
      .pad_in_b(pad_in_b), .pad_out_b(g_out_b), .pad_oe_b(g_oe_b),
      .pad_in_c(pad_in_c), .pad_out_c(g_out_c), .pad_oe_c(g_oe_c)
   );

   // Observation selectors
   localparam int S_RD = 0, S_OUT_A = 1, S_OE_A = 2, S_OUT_B = 3, S_OE_B = 4,
                  S_OUT_C = 5, S_OE_C = 6, S_G_RD = 7, S_G_OE_C = 8, S_G_OUT_C = 9;

   typedef struct {
      int         sel;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   event  chk_ev;
   int    checks = 0, failures = 0;
   bit    done = 1'b0;

   function automatic logic [7:0] observe(input int sel);
      case (sel)
         S_RD:      return rd_data;
         S_OUT_A:   return {4'h0, pad_out_a};
         S_OE_A:    return {4'h0, pad_oe_a};
         S_OUT_B:   return pad_out_b;
         S_OE_B:    return pad_oe_b;
         S_OUT_C:   return pad_out_c;
         S_OE_C:    return pad_oe_c;
         S_G_RD:    return g_rd_data;
         S_G_OE_C:  return g_oe_c;
         default:   return g_out_c;
      endcase
   endfunction

   // Monitor: pops expected items and compares with what the design shows
   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            item_t it;
            logic [7:0] got;
            it  = q.pop_front();
            got = observe(it.sel);
            checks++;
            if (got !== it.exp) begin
               failures++;
               $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, got, it.exp);
            end
         end
      end
   end

   // Driver tasks
   task automatic expect_val(input int sel, input logic [4:0] addr,
                             input logic [7:0] exp, input string tag);
      item_t it;
      @(negedge clk);
      reg_addr = addr;
      #1;
      it.sel = sel; it.exp = exp; it.tag = tag;
      q.push_back(it);
      ->chk_ev;
      #0;
   endtask

   task automatic bus_write(input logic [4:0] addr, input logic [7:0] data);
      @(negedge clk);
      reg_addr = addr; reg_wdata = data; reg_wr_en = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic dir_load(input logic [4:0] addr, input logic [7:0] data);
      @(negedge clk);
      reg_addr = addr; reg_wdata = data; dir_ld = 1'b1;
      @(negedge clk);
      dir_ld = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      por_n = 1'b0; rst_n = 1'b0; reg_wr_en = 1'b0; dir_ld = 1'b0;
      reg_addr = '0; reg_wdata = '0;
      pad_in_a = 4'hF; pad_in_b = 8'h3C; pad_in_c = 8'h81;
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;

      // R1: every pin an input after power-on
      expect_val(S_OE_A, 5'h00, 8'h00, "R1 oe_a after por");
      expect_val(S_OE_B, 5'h00, 8'h00, "R1 oe_b after por");
      expect_val(S_OE_C, 5'h00, 8'h00, "R1 oe_c after por");

      // R2: direction load of port B only
      dir_load(5'h06, 8'h0F);
      expect_val(S_OE_B, 5'h00, 8'hF0, "R2 oe_b per-bit");
      expect_val(S_OE_A, 5'h00, 8'h00, "R2 oe_a untouched");
      expect_val(S_OE_C, 5'h00, 8'h00, "R2 oe_c untouched");

      // R3 / R5: latch writes
      bus_write(5'h06, 8'hA5);
      expect_val(S_OUT_B, 5'h00, 8'hA5, "R3 out_b written");
      bus_write(5'h05, 8'h3C);
      expect_val(S_OUT_A, 5'h00, 8'h0C, "R5 out_a low nibble");
      expect_val(S_OUT_B, 5'h00, 8'hA5, "R3 out_b unchanged by A write");
      bus_write(5'h07, 8'h5A);
      expect_val(S_OUT_C, 5'h00, 8'h5A, "R3 out_c written while input");
      expect_val(S_OE_C, 5'h00, 8'h00, "R3 oe_c stays off");

      // R4: reads return pins, not latch (bit7 driven 1, held 0)
      expect_val(S_RD, 5'h06, 8'h3C, "R4 read B pins");
      expect_val(S_RD, 5'h05, 8'h0F, "R5 read A upper zero");
      expect_val(S_RD, 5'h07, 8'h81, "R4 read C pins");

      // R4: two-edge synchronizer delay
      @(negedge clk);
      pad_in_b = 8'h11;
      expect_val(S_RD, 5'h06, 8'h3C, "R4 old value after one edge");
      expect_val(S_RD, 5'h06, 8'h11, "R4 new value after two edges");

      // R8: unmapped addresses
      expect_val(S_RD, 5'h04, 8'h00, "R8 addr 04");
      expect_val(S_RD, 5'h08, 8'h00, "R8 addr 08");
      expect_val(S_RD, 5'h1F, 8'h00, "R8 addr 1F");

      // R2: per-bit on port A, and load to a non-port address ignored
      dir_load(5'h05, 8'hF5);
      expect_val(S_OE_A, 5'h00, 8'h0A, "R2 oe_a per-bit");
      dir_load(5'h04, 8'h00);
      expect_val(S_OE_A, 5'h00, 8'h0A, "R2 non-port load oe_a");
      expect_val(S_OE_B, 5'h00, 8'hF0, "R2 non-port load oe_b");
      expect_val(S_OE_C, 5'h00, 8'h00, "R2 non-port load oe_c");

      // R1 / R6: non-power-on reset
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      expect_val(S_OE_A, 5'h00, 8'h00, "R1 oe_a after rst");
      expect_val(S_OE_B, 5'h00, 8'h00, "R1 oe_b after rst");
      expect_val(S_OUT_A, 5'h00, 8'h0C, "R6 out_a kept");
      expect_val(S_OUT_B, 5'h00, 8'hA5, "R6 out_b kept");
      expect_val(S_OUT_C, 5'h00, 8'h5A, "R6 out_c kept");

      // R7: register-mode port C on uut_gpr
      expect_val(S_G_RD, 5'h07, 8'h5A, "R7 gpr read ignores pins");
      bus_write(5'h07, 8'h77);
      expect_val(S_G_RD, 5'h07, 8'h77, "R7 gpr rewrite");
      dir_load(5'h07, 8'h00);
      expect_val(S_G_OE_C, 5'h00, 8'h00, "R7 gpr oe stays 0");
      expect_val(S_G_OUT_C, 5'h00, 8'h00, "R7 gpr out stays 0");
      expect_val(S_OE_C, 5'h00, 8'hFF, "R2 io port C drives");

      done = 1'b1;
      summary();
      $finish;
   end

   // Watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
         $finish;
      end
   end
endmodule